// File: doc/BRIEF.md
# Carry-Aware Rotate Unit

This block rotates a data word by a variable number of bit positions. It supports four operations. Two are plain rotations of the word alone, one left and one right. The other two treat the incoming carry flag as one extra bit on top of the word, so the rotation runs over WIDTH+1 bits, again left or right. The rotate amount comes from one of three sources, chosen by an 8-bit source code: an immediate byte, a fixed amount of one, or a count register. The immediate and the count register are masked to log2(WIDTH) bits before use.

A request is applied for one cycle. One cycle later the unit presents the new word, the new carry flag and the new overflow flag. Each of the three comes with its own write strobe, so that the surrounding datapath updates only what the operation defines. All other status flags are left to the caller. A masked count of zero writes nothing. Overflow is written by the right-rotate forms only when they move by exactly one place.

Top module: `rc_rot_unit`

## Requirements
- R1: Source code 0xC1 takes the rotate amount from the immediate byte, masked to its low log2(WIDTH) bits. Code 0xD1 forces an amount of one. Code 0xD3 takes the count register, masked the same way. Any other code behaves as an amount of zero.
- R2: A request whose masked amount is zero raises none of the three write strobes. The result, carry and overflow outputs keep their previous values.
- R3: Operation code 0 is a plain left rotation. The new carry is result bit 0, and overflow is that carry XOR result bit WIDTH-1. Both flags are written.
- R4: Operation code 1 is a plain right rotation. The new carry is result bit WIDTH-1 and is always written.
- R5: Operation code 2 rotates the (WIDTH+1)-bit value {carry_in, operand} left by n. The new carry is operand bit WIDTH-n. Overflow is that new carry XOR result bit WIDTH-1. Both flags are written.
- R6: Operation code 3 rotates {carry_in, operand} right by n. The new carry is operand bit n-1. Carry is always written.
- R7: For operation codes 1 and 3, overflow is written only when n equals 1, with the value operand bit WIDTH-1 XOR result bit WIDTH-1. For any other amount the overflow strobe stays low and the overflow output holds. For codes 0 and 2 the overflow strobe goes high whenever n is nonzero.
- R8: The outputs for a request appear in the cycle after the request is sampled. While req is low, all strobes are low and all outputs hold.
- R9: After reset, all outputs and strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request valid this cycle |
| op_sel | input | 2 | Operation: 0 rotate left, 1 rotate right, 2 left through carry, 3 right through carry |
| operand | input | WIDTH | Word to rotate |
| carry_in | input | 1 | Current carry flag |
| cnt_src | input | 8 | Amount source code (0xC1, 0xD1, 0xD3) |
| imm | input | 8 | Immediate amount byte |
| cnt_reg | input | 8 | Count register value |
| result | output | WIDTH | Rotated word |
| result_we | output | 1 | Result write strobe |
| carry_out | output | 1 | New carry flag |
| carry_we | output | 1 | Carry write strobe |
| ovf_out | output | 1 | New overflow flag |
| ovf_we | output | 1 | Overflow write strobe |

## Verification
The hardest cases to reach are at the edges of the 65-bit carry rotation. An amount of 1 must place the old carry in bit 0 (left) or bit 63 (right). An amount of 63 draws the new carry from the operand's opposite end. In both cases, overflow must be held rather than written when a right form moves by more than one place. The stimulus sweeps every amount from 0 to 63 for every operation, with both carry values and several operand patterns. It alternates between the immediate and the count-register sources, and sets the bits above the mask so that a missing mask would show. Because every update is checked against a held model of the previous outputs, an undefined code or an amount of zero shows up as a stale value.

// File: rtl/rc_rot_pkg.sv
package rc_rot_pkg;
   typedef enum logic [1:0] {
      OP_ROL = 2'd0,
      OP_ROR = 2'd1,
      OP_RCL = 2'd2,
      OP_RCR = 2'd3
   } rot_op_e;

   localparam logic [7:0] SRC_IMM  = 8'hC1;
   localparam logic [7:0] SRC_ONE  = 8'hD1;
   localparam logic [7:0] SRC_CREG = 8'hD3;
endpackage

// File: rtl/rc_count_sel.sv
module rc_count_sel #(
   parameter int CNT_W = 6
) (
   input  logic [7:0]       src,
   input  logic [7:0]       imm,
   input  logic [7:0]       creg,
   output logic [CNT_W-1:0] amount
);
   import rc_rot_pkg::*;

   always_comb begin
      unique case (src)
         SRC_IMM:  amount = imm[CNT_W-1:0];
         SRC_ONE:  amount = CNT_W'(1);
         SRC_CREG: amount = creg[CNT_W-1:0];
         default:  amount = '0;
      endcase
   end
endmodule

// File: rtl/rc_rotl.sv
// Left rotator of arbitrary width. The amount is taken modulo W.
// USE_STAGES selects a log-depth barrel or a double-width shift.
module rc_rotl #(
   parameter int W          = 65,
   parameter int AMT_W      = 7,
   parameter bit USE_STAGES = 1'b1
) (
   input  logic [W-1:0]     din,
   input  logic [AMT_W-1:0] amt,
   output logic [W-1:0]     dout
);
   generate
      if (USE_STAGES) begin : g_barrel
         logic [W-1:0] stage [AMT_W+1];
         assign stage[0] = din;
         for (genvar s = 0; s < AMT_W; s++) begin : g_st
            localparam int SH = (1 << s) % W;
            if (SH == 0) begin : g_pass
               assign stage[s+1] = stage[s];
            end else begin : g_rot
               assign stage[s+1] = amt[s] ?
                  {stage[s][W-1-SH:0], stage[s][W-1:W-SH]} : stage[s];
            end
         end
         assign dout = stage[AMT_W];
      end else begin : g_shift
         logic [2*W-1:0] dbl;
         assign dbl  = {din, din} << amt;
         assign dout = dbl[2*W-1:W];
      end
   endgenerate
endmodule

// File: rtl/rc_flag_gen.sv
module rc_flag_gen #(
   parameter int W     = 64,
   parameter int CNT_W = 6
) (
   input  rc_rot_pkg::rot_op_e op,
   input  logic [CNT_W-1:0]    amount,
   input  logic                orig_msb,
   input  logic [W-1:0]        plain_res,
   input  logic [W:0]          carry_res,
   output logic [W-1:0]        res,
   output logic                cf,
   output logic                of,
   output logic                wr_en,
   output logic                of_en
);
   import rc_rot_pkg::*;

   logic is_one;
   assign is_one = (amount == CNT_W'(1));
   assign wr_en  = (amount != '0);

   always_comb begin
      res   = plain_res;
      cf    = 1'b0;
      of    = 1'b0;
      of_en = 1'b0;
      unique case (op)
         OP_ROL: begin
            cf    = plain_res[0];
            of    = plain_res[0] ^ plain_res[W-1];
            of_en = wr_en;
         end
         OP_ROR: begin
            cf    = plain_res[W-1];
            of    = orig_msb ^ plain_res[W-1];
            of_en = is_one;
         end
         OP_RCL: begin
            res   = carry_res[W-1:0];
            cf    = carry_res[W];
            of    = carry_res[W] ^ carry_res[W-1];
            of_en = wr_en;
         end
         OP_RCR: begin
            res   = carry_res[W-1:0];
            cf    = carry_res[W];
            of    = orig_msb ^ carry_res[W-1];
            of_en = is_one;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rc_rot_unit.sv
module rc_rot_unit #(
   parameter int WIDTH      = 64,
   parameter bit USE_STAGES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [1:0]       op_sel,
   input  logic [WIDTH-1:0] operand,
   input  logic             carry_in,
   input  logic [7:0]       cnt_src,
   input  logic [7:0]       imm,
   input  logic [7:0]       cnt_reg,
   output logic [WIDTH-1:0] result,
   output logic             result_we,
   output logic             carry_out,
   output logic             carry_we,
   output logic             ovf_out,
   output logic             ovf_we
);
   import rc_rot_pkg::*;

   localparam int CNT_W = $clog2(WIDTH);
   localparam int AMT_W = CNT_W + 1;

   initial begin
      if (WIDTH < 8 || (1 << CNT_W) != WIDTH)
         $error("rc_rot_unit: WIDTH must be a power of two of at least 8");
      if (CNT_W > 8)
         $error("rc_rot_unit: amount field wider than the 8-bit count inputs");
   end

   rot_op_e            op;
   logic [CNT_W-1:0]   amount;
   logic [CNT_W-1:0]   plain_amt;
   logic [AMT_W-1:0]   carry_amt;
   logic [WIDTH-1:0]   plain_res;
   logic [WIDTH:0]     carry_res;
   logic [WIDTH-1:0]   nxt_res;
   logic               nxt_cf, nxt_of, nxt_wr, nxt_of_en;

   assign op = rot_op_e'(op_sel);

   rc_count_sel #(.CNT_W(CNT_W)) u_cnt (
      .src(cnt_src), .imm(imm), .creg(cnt_reg), .amount(amount)
   );

   // A right rotation by n is a left rotation by the ring length minus n.
   assign plain_amt = op_sel[0] ? CNT_W'(WIDTH - int'(amount)) : amount;
   assign carry_amt = op_sel[0] ? AMT_W'(WIDTH + 1 - int'(amount))
                                : AMT_W'(amount);

   rc_rotl #(.W(WIDTH), .AMT_W(CNT_W), .USE_STAGES(USE_STAGES)) u_rot_plain (
      .din(operand), .amt(plain_amt), .dout(plain_res)
   );

   rc_rotl #(.W(WIDTH+1), .AMT_W(AMT_W), .USE_STAGES(USE_STAGES)) u_rot_carry (
      .din({carry_in, operand}), .amt(carry_amt), .dout(carry_res)
   );

   rc_flag_gen #(.W(WIDTH), .CNT_W(CNT_W)) u_flags (
      .op(op), .amount(amount), .orig_msb(operand[WIDTH-1]),
      .plain_res(plain_res), .carry_res(carry_res),
      .res(nxt_res), .cf(nxt_cf), .of(nxt_of),
      .wr_en(nxt_wr), .of_en(nxt_of_en)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result    <= '0;
         result_we <= 1'b0;
         carry_out <= 1'b0;
         carry_we  <= 1'b0;
         ovf_out   <= 1'b0;
         ovf_we    <= 1'b0;
      end else begin
         result_we <= req && nxt_wr;
         carry_we  <= req && nxt_wr;
         ovf_we    <= req && nxt_of_en;
         if (req && nxt_wr) begin
            result    <= nxt_res;
            carry_out <= nxt_cf;
         end
         if (req && nxt_of_en)
            ovf_out <= nxt_of;
      end
   end
endmodule

// File: rtl/rc_rot_chk.sv
module rc_rot_chk #(
   parameter int WIDTH = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req,
   input logic [1:0]       op_sel,
   input logic [7:0]       cnt_src,
   input logic [7:0]       imm,
   input logic [WIDTH-1:0] result,
   input logic             result_we,
   input logic             carry_out,
   input logic             carry_we,
   input logic             ovf_out,
   input logic             ovf_we
);
   localparam int CNT_W = $clog2(WIDTH);

   AST_ONE_SRC_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (req && cnt_src == 8'hD1) |=> (result_we && carry_we)); // R1

   AST_BAD_SRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req && cnt_src != 8'hC1 && cnt_src != 8'hD1 && cnt_src != 8'hD3)
      |=> (!result_we && !carry_we && !ovf_we)); // R2

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !result_we |-> ($stable(result) && $stable(carry_out))); // R2

   AST_OVF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_we |-> $stable(ovf_out)); // R7

   AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (result_we && $past(op_sel) == 2'd0) |-> (carry_out == result[0])); // R3

   AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (result_we && $past(op_sel) == 2'd1)
      |-> (carry_out == result[WIDTH-1])); // R4

   AST_RIGHT_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (req && op_sel[0] && cnt_src == 8'hC1 && imm[CNT_W-1:0] != CNT_W'(1))
      |=> !ovf_we); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (!result_we && !carry_we && !ovf_we)); // R8

   AST_OVF_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_we |-> result_we); // R7
endmodule

bind rc_rot_unit rc_rot_chk #(.WIDTH(WIDTH)) u_rc_rot_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .op_sel(op_sel),
   .cnt_src(cnt_src), .imm(imm), .result(result), .result_we(result_we),
   .carry_out(carry_out), .carry_we(carry_we),
   .ovf_out(ovf_out), .ovf_we(ovf_we)
);

// File: tb/test_rc_rot_unit.sv
module test_rc_rot_unit;
   localparam int W        = 64;
   localparam time CLK_PER = 10ns;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         req;
   logic [1:0]   op_sel;
   logic [W-1:0] operand;
   logic         carry_in;
   logic [7:0]   cnt_src, imm, cnt_reg;
   logic [W-1:0] result;
   logic         result_we, carry_out, carry_we, ovf_out, ovf_we;

   int n_tests = 0;
   int n_fail  = 0;

   // model of held outputs
   logic [W-1:0] m_res;
   logic         m_cf, m_of;

   always #(CLK_PER/2) clk = ~clk;

   rc_rot_unit #(.WIDTH(W)) i_rc_rot_unit (
      .clk(clk), .rst_n(rst_n), .req(req), .op_sel(op_sel),
      .operand(operand), .carry_in(carry_in), .cnt_src(cnt_src),
      .imm(imm), .cnt_reg(cnt_reg), .result(result), .result_we(result_we),
      .carry_out(carry_out), .carry_we(carry_we),
      .ovf_out(ovf_out), .ovf_we(ovf_we)
   );

   task automatic check(input string tag, input logic [W+4:0] act,
                        input logic [W+4:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // bit-serial reference model
   task automatic model(input int op, input logic [W-1:0] a, input logic c,
                        input int n, output logic [W-1:0] r,
                        output logic cf, output logic of, output logic ofen);
      logic [W-1:0] x;
      logic         cc, t;
      x  = a;
      cc = c;
      for (int i = 0; i < n; i++) begin
         case (op)
            0: x = {x[W-2:0], x[W-1]};
            1: x = {x[0], x[W-1:1]};
            2: begin t = x[W-1]; x = {x[W-2:0], cc}; cc = t; end
            default: begin t = x[0]; x = {cc, x[W-1:1]}; cc = t; end
         endcase
      end
      r = x;
      case (op)
         0: begin cf = x[0];   of = x[0] ^ x[W-1]; ofen = 1'b1; end
         1: begin cf = x[W-1]; of = a[W-1] ^ x[W-1]; ofen = (n == 1); end
         2: begin cf = cc;     of = cc ^ x[W-1];   ofen = 1'b1; end
         default: begin cf = cc; of = a[W-1] ^ x[W-1]; ofen = (n == 1); end
      endcase
   endtask

   // issue one request, n is the effective amount the bench expects
   task automatic issue(input string tag, input int op, input logic [W-1:0] a,
                        input logic c, input logic [7:0] src,
                        input logic [7:0] im, input logic [7:0] cr,
                        input int n);
      logic [W-1:0] r;
      logic cf, of, ofen, we;
      @(negedge clk);
      req = 1'b1; op_sel = op[1:0]; operand = a; carry_in = c;
      cnt_src = src; imm = im; cnt_reg = cr;
      @(negedge clk);
      req = 1'b0;
      model(op, a, c, n, r, cf, of, ofen);
      we = (n != 0);
      if (!we) ofen = 1'b0;
      if (we) begin m_res = r; m_cf = cf; end
      if (ofen) m_of = of;
      check(tag, {result, result_we, carry_out, carry_we, ovf_out, ovf_we},
            {m_res, we, m_cf, we, m_of, ofen});
   endtask

   initial begin
      #(CLK_PER * 100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] pats [3];
      pats[0] = 64'h8000_0000_0000_0001;
      pats[1] = 64'hDEAD_BEEF_0123_4567;
      pats[2] = 64'h7F00_00FF_5A5A_C3C3;
      rst_n = 1'b0; req = 1'b0; op_sel = '0; operand = '0; carry_in = 1'b0;
      cnt_src = '0; imm = '0; cnt_reg = '0;
      m_res = '0; m_cf = 1'b0; m_of = 1'b0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 reset", {result, result_we, carry_out, carry_we, ovf_out, ovf_we},
            '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle after reset",
            {result, result_we, carry_out, carry_we, ovf_out, ovf_we}, '0);

      // R3 R4 R5 R6 R7 sweep over every amount, both carries, all patterns
      for (int op = 0; op < 4; op++) begin
         for (int n = 0; n < W; n++) begin
            for (int p = 0; p < 3; p++) begin
               for (int c = 0; c < 2; c++) begin
                  string tg;
                  tg = $sformatf("R%0d op%0d n%0d p%0d c%0d", op + 3, op, n, p, c);
                  if (((n + p + c) & 1) == 0)
                     issue(tg, op, pats[p] ^ {W{c[0]}}, c[0], 8'hC1,
                           8'(n) | 8'hC0, 8'h01, n);   // R1 immediate masked
                  else
                     issue(tg, op, pats[p] ^ {W{c[0]}}, c[0], 8'hD3,
                           8'h02, 8'(n) | 8'h40, n);  // R1 register masked
               end
            end
         end
      end

      // R1 constant-one source ignores imm and cnt_reg
      for (int op = 0; op < 4; op++)
         issue("R1 one source", op, pats[1], 1'b1, 8'hD1, 8'h05, 8'h07, 1);
      // R7 right forms at n=2 keep overflow; left form at n=2 writes it
      issue("R7 rol sets ovf", 0, 64'h4000_0000_0000_0000, 1'b0, 8'hD3, 8'h0, 8'h02, 2);
      issue("R7 rcr n2 holds ovf", 3, 64'h8000_0000_0000_0000, 1'b1, 8'hC1, 8'h02, 8'h0, 2);
      issue("R7 ror n1 writes ovf", 1, 64'h1, 1'b0, 8'hD1, 8'h0, 8'h0, 1);
      // R2 zero amount and unknown codes write nothing
      issue("R2 zero amount", 2, pats[2], 1'b1, 8'hC1, 8'h40, 8'h0, 0);
      issue("R1 unknown code", 0, pats[0], 1'b0, 8'hC0, 8'h05, 8'h05, 0);
      issue("R1 unknown code2", 3, pats[1], 1'b1, 8'hD2, 8'h03, 8'h03, 0);
      // R8 outputs hold across idle cycles
      repeat (3) @(negedge clk);
      check("R8 hold", {result, result_we, carry_out, carry_we, ovf_out, ovf_we},
            {m_res, 1'b0, m_cf, 1'b0, m_of, 1'b0});

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule